// File: doc/BRIEF.md
# Row Write Latch Programmer

This block collects data words for one flash row in a bank of 32 write latches. It then either commits the whole bank into a row of a behavioral flash array or erases a row of that array. Every action starts from a one-cycle unlock strobe, which a separate guard block produces. When the strobe arrives, the load-only flag and the erase flag decide what the block does. A strobe can store a single word into a latch. It can store a final word and then program the whole row. It can also erase a whole row.

Programming follows flash semantics. Bits can only be cleared, and no erase happens before a write. The bank therefore only needs the words that are to change. A latch that was never loaded holds the blank value, so the matching word in the row stays as it was. A program or erase keeps `busy_o` high for a fixed number of cycles. The latch bank returns to blank when the operation ends. A combinational read port shows the array contents.

Top module: `row_latch_prog`

## Requirements
- R1: The word address has two parts: `addr_i[4:0]` selects one of the 32 latches and `addr_i[14:5]` selects the row. Rows other than the addressed one are never changed.
- R2: A strobe with `load_only_i`=1 and `erase_i`=0 while idle stores `data_i` into the addressed latch only. `busy_o` stays low and the array is unchanged.
- R3: A strobe with `load_only_i`=0 and `erase_i`=0 while idle stores `data_i` into the addressed latch. All 32 latches are then programmed into the row given by that strobe's address.
- R4: Programming never erases. Each stored word becomes the bitwise AND of its old value and its latch value.
- R5: A strobe with `erase_i`=1 while idle sets all 32 words of the addressed row to 0x3FFF. The strobe ignores `load_only_i` and loads no latch.
- R6: `busy_o` rises on the clock edge that takes the strobe. It stays high for exactly PROG_CYCLES cycles for a program, or exactly ERASE_CYCLES cycles for an erase. The new array contents appear on `rd_data_o` from the edge on which `busy_o` falls.
- R7: Strobes that arrive while `busy_o` is high are ignored. They neither load a latch nor start an operation, and they do not lengthen the busy time.
- R8: When any program or erase finishes, every latch returns to 0x3FFF. A later partial-row program therefore leaves its unloaded words unchanged.
- R9: Reset clears `busy_o` and sets every latch and every array word to 0x3FFF.
- R10: The array models ARRAY_ROWS rows, with 8 rows by default. Row numbers are taken modulo ARRAY_ROWS for both writes and reads. `rd_data_o` is a combinational read of the word at `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Unlock strobe, one cycle per action |
| addr_i | input | 15 | Word address: row in [14:5], latch in [4:0] |
| data_i | input | 14 | Data word to load |
| load_only_i | input | 1 | 1: load a latch only; 0: load and commit the row |
| erase_i | input | 1 | 1: erase the addressed row |
| rd_addr_i | input | 15 | Array read address |
| rd_data_o | output | 14 | Array word at `rd_addr_i` |
| busy_o | output | 1 | Program or erase in progress |

## Verification
Timing of each result:
- A latch load takes effect on the strobe edge. It can only be seen through a later commit, so the bench reads the array only after a program or erase has ended.
- `busy_o` is registered and rises on the strobe edge. It falls PROG_CYCLES or ERASE_CYCLES edges later, and the array is written on that same edge.
- The bench drives inputs and samples outputs on falling edges. It counts the falling edges at which `busy_o` is high to measure the operation length. It then sets `rd_addr_i` and compares `rd_data_o` one time step later, because the read path has no register.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } rlp_state_e;
endpackage

// File: rtl/rlp_latch_bank.sv
module rlp_latch_bank #(
  parameter int DATA_W  = 14,
  parameter int IDX_W   = 5,
  localparam int N_LATCH = 1 << IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           data_i,
  input  logic                        clear_i,
  output logic [N_LATCH*DATA_W-1:0]   latch_o
);
  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= BLANK;
      else if (clear_i)                         q <= BLANK;
      else if (load_i && idx_i == IDX_W'(g))    q <= data_i;
    end
    assign latch_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rlp_flash_array.sv
module rlp_flash_array #(
  parameter int DATA_W     = 14,
  parameter int IDX_W      = 5,
  parameter int ROW_W      = 10,
  parameter int ARRAY_ROWS = 8,
  localparam int N_LATCH   = 1 << IDX_W,
  localparam int SEL_W     = $clog2(ARRAY_ROWS),
  localparam int DEPTH     = ARRAY_ROWS * N_LATCH
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       prog_i,
  input  logic                       erase_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [N_LATCH*DATA_W-1:0]  latch_i,
  input  logic [ROW_W-1:0]           rd_row_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o
);
  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [SEL_W-1:0]  wr_sel;
  logic [SEL_W-1:0]  rd_sel;
  logic              unused_row_bits;

  assign wr_sel = row_i[SEL_W-1:0];
  assign rd_sel = rd_row_i[SEL_W-1:0];
  assign unused_row_bits = ^{row_i[ROW_W-1:SEL_W], rd_row_i[ROW_W-1:SEL_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= BLANK;
    end else if (erase_i) begin
      for (int i = 0; i < N_LATCH; i++) mem_q[{wr_sel, IDX_W'(i)}] <= BLANK;
    end else if (prog_i) begin
      // flash cells can only be cleared
      for (int i = 0; i < N_LATCH; i++)
        mem_q[{wr_sel, IDX_W'(i)}] <= mem_q[{wr_sel, IDX_W'(i)}] & latch_i[i*DATA_W +: DATA_W];
    end
  end

  assign rd_data_o = mem_q[{rd_sel, rd_idx_i}];
endmodule

// File: rtl/rlp_seq.sv
module rlp_seq
  import rlp_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 10,
  localparam int MAX_CYC     = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W       = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             load_only_i,
  input  logic             erase_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             latch_we_o,
  output logic             prog_done_o,
  output logic             erase_done_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_o
);
  rlp_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             accept;

  assign accept       = strobe_i && (state_q == ST_IDLE);
  assign latch_we_o   = accept && !erase_i;
  assign prog_done_o  = (state_q == ST_PROG)  && (cnt_q == '0);
  assign erase_done_o = (state_q == ST_ERASE) && (cnt_q == '0);
  assign row_o        = row_q;
  assign busy_o       = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && erase_i) begin
            state_q <= ST_ERASE;
            cnt_q   <= CNT_W'(ERASE_CYCLES - 1);
            row_q   <= row_i;
          end else if (accept && !load_only_i) begin
            state_q <= ST_PROG;
            cnt_q   <= CNT_W'(PROG_CYCLES - 1);
            row_q   <= row_i;
          end
        end
        ST_PROG, ST_ERASE: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/row_latch_prog.sv
module row_latch_prog #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 14,
  parameter int IDX_W        = 5,
  parameter int ARRAY_ROWS   = 8,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 10,
  localparam int ROW_W       = ADDR_W - IDX_W,
  localparam int N_LATCH     = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_only_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  logic                      latch_we;
  logic                      prog_done;
  logic                      erase_done;
  logic [ROW_W-1:0]          op_row;
  logic [N_LATCH*DATA_W-1:0] latch_flat;

  rlp_seq #(
    .ROW_W       (ROW_W),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .load_only_i (load_only_i),
    .erase_i     (erase_i),
    .row_i       (addr_i[ADDR_W-1:IDX_W]),
    .latch_we_o  (latch_we),
    .prog_done_o (prog_done),
    .erase_done_o(erase_done),
    .row_o       (op_row),
    .busy_o      (busy_o)
  );

  rlp_latch_bank #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (latch_we),
    .idx_i  (addr_i[IDX_W-1:0]),
    .data_i (data_i),
    .clear_i(prog_done | erase_done),
    .latch_o(latch_flat)
  );

  rlp_flash_array #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .ROW_W     (ROW_W),
    .ARRAY_ROWS(ARRAY_ROWS)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prog_i   (prog_done),
    .erase_i  (erase_done),
    .row_i    (op_row),
    .latch_i  (latch_flat),
    .rd_row_i (rd_addr_i[ADDR_W-1:IDX_W]),
    .rd_idx_i (rd_addr_i[IDX_W-1:0]),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/rlp_checker.sv
module rlp_checker #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 14,
  parameter int N_LATCH = 32,
  parameter int MAX_CYC = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      strobe_i,
  input logic                      load_only_i,
  input logic                      erase_i,
  input logic                      busy_o,
  input logic [ADDR_W-1:0]         rd_addr_i,
  input logic [DATA_W-1:0]         rd_data_o,
  input logic [N_LATCH*DATA_W-1:0] latch_flat_i
);
  logic [31:0] busy_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= '0;
  end

  a_r2_load_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !busy_o && load_only_i && !erase_i) |=> !busy_o);

  a_r3_commit_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !busy_o && !load_only_i && !erase_i) |=> busy_o);

  a_r5_erase_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !busy_o && erase_i) |=> busy_o);

  a_r6_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < MAX_CYC));

  a_r8_latches_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (latch_flat_i == {(N_LATCH*DATA_W){1'b1}}));

  a_r2_array_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(busy_o) == 1'b0 && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind row_latch_prog rlp_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .N_LATCH(N_LATCH),
  .MAX_CYC((PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strobe_i    (strobe_i),
  .load_only_i (load_only_i),
  .erase_i     (erase_i),
  .busy_o      (busy_o),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .latch_flat_i(latch_flat)
);

// File: tb/row_latch_prog_bench.sv
module row_latch_prog_bench;
  localparam int PROG_C  = 6;
  localparam int ERASE_C = 10;
  localparam logic [1:0] OP_LOAD = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_READ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [14:0] addr;
    logic [13:0] data;
    logic [14:0] chk;
    logic [13:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_LOAD,  15'h0060, 14'h1234, 15'h0060, 14'h3FFF}, // R2
    '{OP_LOAD,  15'h0062, 14'h0F0F, 15'h0062, 14'h3FFF}, // R2
    '{OP_PROG,  15'h0065, 14'h2AAA, 15'h0060, 14'h1234}, // R3
    '{OP_READ,  15'h0000, 14'h0000, 15'h0062, 14'h0F0F}, // R3
    '{OP_READ,  15'h0000, 14'h0000, 15'h0065, 14'h2AAA}, // R3
    '{OP_READ,  15'h0000, 14'h0000, 15'h0061, 14'h3FFF}, // R8 unloaded
    '{OP_PROG,  15'h0060, 14'h3C3C, 15'h0060, 14'h1034}, // R4 AND
    '{OP_READ,  15'h0000, 14'h0000, 15'h0062, 14'h0F0F}, // R8 latches blanked
    '{OP_ERASE, 15'h0071, 14'h0000, 15'h0062, 14'h3FFF}, // R5
    '{OP_READ,  15'h0000, 14'h0000, 15'h0060, 14'h3FFF}, // R5
    '{OP_PROG,  15'h007F, 14'h0001, 15'h007F, 14'h0001}, // R3
    '{OP_READ,  15'h0000, 14'h0000, 15'h0071, 14'h3FFF}, // R5 no latch load
    '{OP_PROG,  15'h0164, 14'h00FF, 15'h0064, 14'h00FF}, // R10 alias
    '{OP_READ,  15'h0000, 14'h0000, 15'h0044, 14'h3FFF}  // R1 other row
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [14:0] addr = '0;
  logic [13:0] data = '0;
  logic        load_only = 1'b0;
  logic        erase = 1'b0;
  logic [14:0] rd_addr = '0;
  logic [13:0] rd_data;
  logic        busy;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  row_latch_prog #(.PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)) u_row_latch_prog (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .addr_i(addr), .data_i(data),
    .load_only_i(load_only), .erase_i(erase), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe_op(input logic [1:0] op, input logic [14:0] a, input logic [13:0] d);
    strobe = 1'b1; addr = a; data = d;
    load_only = (op != OP_PROG);
    erase = (op == OP_ERASE);
    @(negedge clk);
    strobe = 1'b0; load_only = 1'b0; erase = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input string req, input logic [14:0] a, input logic [13:0] exp);
    rd_addr = a;
    #1;
    check(req, 32'(rd_data), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    string tag;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 busy", 32'(busy), 32'd0);
    read_chk("R9 array", 15'h0000, 14'h3FFF);
    read_chk("R9 array", 15'h00E0, 14'h3FFF);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_LOAD:  tag = "R2";
        OP_PROG:  tag = "R3";
        OP_ERASE: tag = "R5";
        default:  tag = "R8";
      endcase
      if (VECS[i].op != OP_READ) strobe_op(VECS[i].op, VECS[i].addr, VECS[i].data);
      if (VECS[i].op == OP_LOAD) check("R2 busy", 32'(busy), 32'd0);
      wait_idle(n);
      read_chk(tag, VECS[i].chk, VECS[i].exp);
    end

    // R6 program and erase length
    strobe_op(OP_PROG, 15'h0020, 14'h1111);
    wait_idle(n);
    check("R6 prog cycles", 32'(n), 32'(PROG_C));
    read_chk("R6 prog result", 15'h0020, 14'h1111);
    strobe_op(OP_ERASE, 15'h0020, 14'h0000);
    wait_idle(n);
    check("R6 erase cycles", 32'(n), 32'(ERASE_C));
    read_chk("R6 erase result", 15'h0020, 14'h3FFF);

    // R7 strobes during busy are ignored
    strobe_op(OP_PROG, 15'h0040, 14'h0AAA);
    strobe_op(OP_LOAD, 15'h0041, 14'h0000);
    strobe_op(OP_PROG, 15'h00A0, 14'h0000);
    wait_idle(n);
    check("R7 busy length", 32'(n + 2), 32'(PROG_C));
    read_chk("R7 prog kept", 15'h0040, 14'h0AAA);
    read_chk("R7 no second prog", 15'h00A0, 14'h3FFF);
    strobe_op(OP_PROG, 15'h0042, 14'h3FFF);
    wait_idle(n);
    read_chk("R7 no latch load", 15'h0041, 14'h0000 | 14'h3FFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule